// File: doc/BRIEF.md
# Two-wire serial target with command-pointer register access

This block lets a host on a two-wire serial bus (I2C) read and write four byte-wide registers of a small peripheral. SCL and SDA are sampled by the system clock, which runs at least sixteen times faster than SCL. From those samples the block finds START, repeated START and STOP. It compares the incoming 7-bit address with a fixed six-bit prefix followed by one strap bit. With the default prefix 0b010000, the block answers at 0x20 when the strap is low and at 0x21 when it is high. Two copies can therefore share one bus.

In a write transaction the first byte after the address is always a command byte. Its two low bits set the register pointer. Each further data byte goes to the pointed register as a one-cycle write strobe on a parallel register port. A read starts with a write transaction that carries only the command byte. The host then sends a repeated START and the address with the read bit set. The block returns the pointed register MSB first, once per host ACK. After a NACK it lets go of SDA and waits for STOP or START. The block drives SDA only low, through `sda_oe`, and the pad is open-drain. An active-low asynchronous reset returns the state machine to idle.

State machine: IDLE (bus free) goes to ADDR on START. ADDR goes to ADDR_ACK when the address matches and to IGNORE when it does not. ADDR_ACK goes to CMD (write) or RDATA (read). CMD goes to CMD_ACK, and CMD_ACK goes to WDATA. WDATA goes to WDATA_ACK, and WDATA_ACK goes back to WDATA. RDATA goes to RACK. RACK goes to RDATA when the host sends ACK and to IGNORE when it sends NACK. A START in any state leads to ADDR, and a STOP in any state leads to IDLE.

Top module: `i2c_ptr_target`

## Requirements
- R1: The block pulls SDA low in the ninth clock of the address byte only when the address equals {0b010000, addr_strap}, with the last bit of the byte being R/W (0 = write).
- R2: On an address mismatch the block keeps SDA released. Later bytes get no ACK and cause no register write until the next START.
- R3: The first byte after a write address is the command byte. Its bits [1:0] appear on `reg_sel`, and its bits [7:2] have no effect.
- R4: Each data byte after the command byte is acknowledged and gives exactly one single-cycle `reg_wr` pulse, with that byte on `reg_wdata`. All data bytes of one transaction go to the same `reg_sel`.
- R5: After a repeated START and the address with R/W=1, the block shifts out `reg_rdata` of the pointed register MSB first. SDA changes only while SCL is low.
- R6: A host ACK after a read byte makes the block send the same register again. A host NACK makes it release SDA and ignore SCL clocks until STOP or START.
- R7: While `rst_n` is low, `sda_oe` and `reg_wr` are 0 at once, even in the middle of a byte. After reset the next transaction works normally.
- R8: A STOP returns the block to idle. SCL clocks sent without a START get no ACK and write nothing.
- R9: A repeated START in the middle of a write transaction restarts the address phase. A new command byte and new data then follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| addr_strap | input | 1 | Low bit of the 7-bit target address |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_sel | output | 2 | Register pointer from the command byte |
| reg_wdata | output | 8 | Data byte being written |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Content of the register selected by reg_sel |

## Verification
The hardest state to reach from the ports is an asynchronous reset that lands while the block is holding SDA low for an ACK. The bench reaches it by stopping its own bit sequence partway through the ninth clock of a matching address, with SCL held high. It then drops `rst_n` and checks that the line is freed at once and that the next full transaction still succeeds. The other tricky situations are a NACK followed by stray clocks, and clocks with no START after a STOP. The bench builds both by hand, bit by bit, and checks that SDA stays high and that no write strobe appears.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_e;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s    = scl_pipe[STAGES-1];
    assign sda_s    = sda_pipe[STAGES-1];
    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_shift_unit.sv
module i2c_shift_unit #(
    parameter  int DW = 8,
    localparam int CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_clr,
    input  logic          bit_tick,
    input  logic          sda_bit,
    input  logic          tx_load,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_shift,
    output logic [DW-1:0] rx_byte,
    output logic          byte_full,
    output logic          tx_msb
);
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] tx_q;

    assign byte_full = (cnt_q == CW'(DW));
    assign tx_msb    = tx_q[DW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            rx_byte <= '0;
        end else if (bit_clr) begin
            cnt_q <= '0;
        end else if (bit_tick && !byte_full) begin
            cnt_q   <= cnt_q + 1'b1;
            rx_byte <= {rx_byte[DW-2:0], sda_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '1;
        end else if (tx_load) begin
            tx_q <= tx_data;
        end else if (tx_shift) begin
            tx_q <= {tx_q[DW-2:0], 1'b1};
        end
    end
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
    import i2c_ptr_pkg::*;
#(
    parameter logic [5:0] ADDR_HI     = 6'b010000,
    parameter int         DW          = 8,
    parameter int         PTR_W       = 2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             addr_strap,
    output logic             sda_oe,
    output logic [PTR_W-1:0] reg_sel,
    output logic [DW-1:0]    reg_wdata,
    output logic             reg_wr,
    input  logic [DW-1:0]    reg_rdata
);
    tgt_state_e state_q, state_d;

    logic          scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [DW-1:0] rx_byte;
    logic          byte_full, tx_msb;
    logic          bit_tick, bit_clr, tx_load, tx_shift;
    logic          in_bits, in_ack, addr_ok, fall_full;
    logic          rw_q, mack_q;

    i2c_line_cond #(.STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    i2c_shift_unit #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .bit_clr(bit_clr), .bit_tick(bit_tick),
        .sda_bit(sda_s), .tx_load(tx_load), .tx_data(reg_rdata),
        .tx_shift(tx_shift), .rx_byte(rx_byte), .byte_full(byte_full),
        .tx_msb(tx_msb)
    );

    assign in_bits   = (state_q == ST_ADDR) || (state_q == ST_CMD) ||
                       (state_q == ST_WDATA) || (state_q == ST_RDATA);
    assign in_ack    = (state_q == ST_ADDR_ACK) || (state_q == ST_CMD_ACK) ||
                       (state_q == ST_WDATA_ACK) || (state_q == ST_RACK);
    assign bit_tick  = scl_rise & in_bits;
    assign bit_clr   = start_ev | (scl_fall & in_ack);
    assign fall_full = scl_fall & byte_full;
    assign addr_ok   = (rx_byte[DW-1:1] == {ADDR_HI, addr_strap});
    assign tx_load   = scl_fall & (((state_q == ST_ADDR_ACK) & rw_q) |
                                   ((state_q == ST_RACK) & mack_q));
    assign tx_shift  = scl_fall & (state_q == ST_RDATA) & ~byte_full;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (stop_ev) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (fall_full) state_d = addr_ok ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall)  state_d = rw_q ? ST_RDATA : ST_CMD;
                ST_CMD:       if (fall_full) state_d = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall)  state_d = ST_WDATA;
                ST_WDATA:     if (fall_full) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  state_d = ST_WDATA;
                ST_RDATA:     if (fall_full) state_d = ST_RACK;
                ST_RACK:      if (scl_fall)  state_d = mack_q ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:    state_d = ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~tx_msb;
            default:                               sda_oe = 1'b0;
        endcase
    end

    // Captured fields and register-port strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            reg_sel   <= '0;
            reg_wdata <= '0;
            reg_wr    <= 1'b0;
        end else begin
            reg_wr <= 1'b0;
            if (!stop_ev && !start_ev) begin
                if (state_q == ST_ADDR && fall_full) rw_q <= rx_byte[0];
                if (state_q == ST_CMD && fall_full)  reg_sel <= rx_byte[PTR_W-1:0];
                if (state_q == ST_WDATA && fall_full) begin
                    reg_wdata <= rx_byte;
                    reg_wr    <= 1'b1;
                end
                if (state_q == ST_RACK && scl_rise) mack_q <= ~sda_s;
            end
        end
    end
endmodule

// File: rtl/i2c_ptr_target_chk.sv
module i2c_ptr_target_chk
    import i2c_ptr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       reg_wr,
    input logic [1:0] reg_sel,
    input tgt_state_e st,
    input logic       stop_ev,
    input logic       addr_ok
);
    // R1
    ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && st == ST_ADDR_ACK) |-> addr_ok);

    // R2
    ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGNORE) |-> (!sda_oe && !reg_wr));

    // R3
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $stable(reg_sel));

    // R4
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R5
    sda_lowscl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (st == ST_IDLE));
endmodule

bind i2c_ptr_target i2c_ptr_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .st(state_q),
    .stop_ev(stop_ev), .addr_ok(addr_ok)
);

// File: tb/i2c_ptr_target_test.sv
module i2c_ptr_target_test;
    localparam int Q  = 4;
    localparam int WD = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       strap = 1'b0;
    logic       sda_oe;
    logic [1:0] reg_sel;
    logic [7:0] reg_wdata;
    logic       reg_wr;
    logic [7:0] reg_rdata;
    logic       sda_line;

    logic [7:0] bank [4];
    logic [7:0] exp_bank [4];
    int         wr_cnt = 0;
    int         n_chk = 0;
    int         n_bad = 0;
    int         cyc = 0;

    always #10 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = bank[reg_sel];

    i2c_ptr_target uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_strap(strap), .sda_oe(sda_oe), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata)
    );

    // Peripheral model behind the register port
    always @(posedge clk) begin
        if (rst_n && reg_wr) begin
            bank[reg_sel] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: act=%0d exp<%0d", cyc, WD);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic m_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic wbit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(b);
        acked = ~b;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            v[i] = b;
        end
        wbit(~give_ack);
    endtask

    initial begin
        logic       ack, ack2, b;
        logic [7:0] rd;
        int         w0;

        for (int p = 0; p < 4; p++) begin
            bank[p]     = 8'h00;
            exp_bank[p] = 8'h00;
        end
        tick(5);
        // R7 reset state
        check(sda_oe == 1'b0, "R7 reset sda_oe", int'(sda_oe), 0);
        check(reg_wr == 1'b0, "R7 reset reg_wr", int'(reg_wr), 0);
        rst_n = 1'b1;
        tick(5);

        // R1/R2 address sweep for both strap values
        for (int s = 0; s < 2; s++) begin
            strap = s[0];
            for (int a = 0; a < 128; a++) begin
                w0 = wr_cnt;
                m_start();
                wbyte({a[6:0], 1'b0}, ack);
                check(ack == (a == 32 + s), "R1 address ack", int'(ack), int'(a == 32 + s));
                if (a != 32 + s && a[3:0] == 4'd5) begin
                    wbyte(8'h01, ack2);
                    check(!ack2, "R2 no ack after mismatch", int'(ack2), 0);
                    wbyte(8'h77, ack2);
                    check(!ack2, "R2 no ack data byte", int'(ack2), 0);
                end
                m_stop();
                tick(2);
                check(wr_cnt == w0, "R2 no write", wr_cnt, w0);
            end
        end

        // R3/R4 writes, command upper bits set, three bytes per register
        strap = 1'b1;
        for (int p = 0; p < 4; p++) begin
            w0 = wr_cnt;
            m_start();
            wbyte(8'h42, ack);
            check(ack, "R1 ack 0x21 write", int'(ack), 1);
            wbyte({6'b101101 ^ 6'(p * 9), p[1:0]}, ack);
            check(ack, "R3 command ack", int'(ack), 1);
            check(reg_sel == p[1:0], "R3 reg_sel", int'(reg_sel), p);
            for (int k = 0; k < 3; k++) begin
                exp_bank[p] = 8'((p * 37 + k * 11 + 3) ^ 8'h96);
                wbyte(exp_bank[p], ack);
                check(ack, "R4 data ack", int'(ack), 1);
                check(reg_sel == p[1:0], "R4 same register", int'(reg_sel), p);
            end
            m_stop();
            tick(2);
            check(wr_cnt == w0 + 3, "R4 write count", wr_cnt, w0 + 3);
            check(bank[p] == exp_bank[p], "R4 register content", int'(bank[p]), int'(exp_bank[p]));
        end

        // R5/R6 reads via repeated START
        for (int p = 0; p < 4; p++) begin
            w0 = wr_cnt;
            m_start();
            wbyte(8'h42, ack);
            wbyte({6'b0, p[1:0]}, ack);
            m_start();
            wbyte(8'h43, ack);
            check(ack, "R5 read address ack", int'(ack), 1);
            for (int k = 0; k < 3; k++) begin
                rbyte(k < 2, rd);
                check(rd == exp_bank[p], "R6 read byte", int'(rd), int'(exp_bank[p]));
            end
            rbit(b);
            check(b == 1'b1, "R6 released after NACK", int'(b), 1);
            check(sda_oe == 1'b0, "R6 sda_oe after NACK", int'(sda_oe), 0);
            m_stop();
            tick(2);
            check(wr_cnt == w0, "R5 read writes nothing", wr_cnt, w0);
        end

        // R9 repeated START inside a write
        m_start();
        wbyte(8'h42, ack);
        wbyte(8'h02, ack);
        exp_bank[2] = 8'h5A;
        wbyte(8'h5A, ack);
        m_start();
        wbyte(8'h42, ack);
        check(ack, "R9 address after Sr", int'(ack), 1);
        wbyte(8'h03, ack);
        check(reg_sel == 2'd3, "R9 new command", int'(reg_sel), 3);
        exp_bank[3] = 8'hC3;
        wbyte(8'hC3, ack);
        m_start();
        wbyte(8'h40, ack);
        check(!ack, "R9 wrong address after Sr", int'(ack), 0);
        m_stop();
        tick(2);
        check(bank[2] == exp_bank[2], "R9 first register", int'(bank[2]), int'(exp_bank[2]));
        check(bank[3] == exp_bank[3], "R9 second register", int'(bank[3]), int'(exp_bank[3]));

        // R8 clocks without START after STOP
        w0 = wr_cnt;
        wbyte(8'h42, ack);
        check(!ack, "R8 no ack without START", int'(ack), 0);
        wbyte(8'h01, ack);
        check(!ack, "R8 no ack second byte", int'(ack), 0);
        m_stop();
        tick(2);
        check(wr_cnt == w0, "R8 no write", wr_cnt, w0);

        // R7 reset while acknowledging
        m_start();
        for (int i = 7; i >= 0; i--) wbit(ack_addr_bit(i));
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        check(sda_oe == 1'b1, "R1 ack held in ninth clock", int'(sda_oe), 1);
        rst_n = 1'b0;
        #1;
        check(sda_oe == 1'b0, "R7 async release", int'(sda_oe), 0);
        tick(3);
        rst_n = 1'b1;
        scl_m = 1'b0; tick(Q);
        m_stop();
        tick(4);
        m_start();
        wbyte(8'h42, ack);
        check(ack, "R7 address after reset", int'(ack), 1);
        wbyte(8'h01, ack);
        exp_bank[1] = 8'hE7;
        wbyte(8'hE7, ack);
        m_stop();
        tick(2);
        check(bank[1] == exp_bank[1], "R7 write after reset", int'(bank[1]), int'(exp_bank[1]));

        summary();
        $finish;
    end

    function automatic logic ack_addr_bit(input int i);
        logic [7:0] a = 8'h42;
        return a[i];
    endfunction
endmodule